// File: doc/BRIEF.md
# Synthesizer Divider-Word Calculator

This block turns a requested output frequency, given in hertz, into the six-byte register image that a programmable clock synthesizer needs. The synthesizer makes its output as a crystal frequency times a fixed-point multiplier, divided by a high-speed divider and an output divider. The calculator first places the request in one of 24 fixed frequency bands. It then reads that band's divider pair and its precomputed constant from a writable table. A bit-serial long division produces the multiplier, and the result is packed into the cross-byte layout that the synthesizer decodes.

Each table entry holds a 32-bit constant K, equal to 256 × crystal ÷ (HS × N1), together with the 3-bit high-speed divider index and the value N1 − 1. A controller loads the entries after it has calibrated the crystal. After that it issues one request at a time with a start strobe and waits for the done pulse. A request outside the supported range is rejected at once, and the previous result is kept.

Top module: `freqword_calc`

## Requirements
- R1: After reset, the image output and the band output are zero, and the done and error outputs are low.
- R2: A valid request reports the highest band whose lower limit is at or below the request. The band limits in MHz are 10, 11, 12, 13, 15, 17, 19, 21, 23, 25, 28, 32, 36, 41, 47, 54, 61, 70, 81, 90, 101, 111, 128 and 135, for bands 0 to 23.
- R3: The multiplier is floor(F × 2^36 ÷ K), kept to 38 bits: 10 integer bits above 28 fraction bits. F is the request and K is the constant stored for the selected band.
- R4: The 48-bit image holds six bytes, the first byte in bits [47:40]. Byte 0 is {HS index[2:0], (N1−1)[6:2]}. Byte 1 is {(N1−1)[1:0], multiplier[37:32]}. Bytes 2 to 5 hold multiplier[31:0], most significant byte first. The HS index is HS − 4: 4→0, 5→1, 6→2, 7→3, 9→5, 11→7.
- R5: A request of 14,025,000 Hz in a band loaded with HS index 7 and N1 − 1 = 33 gives 0xE8 and 0x42 as the first two image bytes.
- R6: A request below 10,000,000 Hz, or at or above 157,000,000 Hz, raises the error output for exactly the cycle after the start. No done pulse follows, and the image and band outputs stay unchanged.
- R7: For a valid request landing in band b, done is high for exactly one cycle, b + 40 clock edges after the edge that samples start.
- R8: A start strobe that arrives while a request is in progress is ignored. It neither raises the error output nor changes the result of the request in progress.
- R9: A table write takes effect for every later request in that band, so rewriting an entry changes the next result that uses it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, one cycle |
| freq_i | input | 32 | Requested frequency in Hz, sampled with start |
| tbl_we_i | input | 1 | Table write enable |
| tbl_idx_i | input | 5 | Band number of the entry to write |
| tbl_k_i | input | 32 | Band constant K |
| tbl_hs_idx_i | input | 3 | High-speed divider index (HS − 4) |
| tbl_n1m1_i | input | 7 | Output divider minus one |
| img_o | output | 48 | Packed six-byte register image |
| band_o | output | 5 | Band of the last accepted request |
| done_o | output | 1 | One-cycle result-valid pulse |
| err_o | output | 1 | One-cycle out-of-range pulse |

## Verification
The bench loads a different divider pair into every band. For each band it requests the exact lower limit, one hertz below the next limit, and a point in between. A search that is off by one at a limit, or that stops one step early or late, shows up as a wrong band and a wrong latency. The multiplier is compared against a wide-integer quotient computed in the bench, so a dropped fraction bit or a wrong scaling shift changes the packed bytes. Rejected frequencies on both sides of the range, a start strobe during a busy request, and a rewritten entry check that stale images, spurious errors and stale constants are caught.

// File: rtl/freqword_pkg.sv
package freqword_pkg;

    localparam int BAND_N  = 24;
    localparam int BAND_W  = $clog2(BAND_N);
    localparam int FREQ_W  = 32;
    localparam int CONST_W = 32;
    localparam int INT_W   = 10;
    localparam int FRAC_W  = 28;
    localparam int MULT_W  = INT_W + FRAC_W;
    // the band constant carries an extra x256 factor
    localparam int SCALE_SH = FRAC_W + 8;
    localparam int HSI_W   = 3;
    localparam int N1_W    = 7;
    localparam int IMG_W   = 48;

    typedef struct packed {
        logic [CONST_W-1:0] k;
        logic [HSI_W-1:0]   hs_idx;
        logic [N1_W-1:0]    n1m1;
    } band_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_DIVIDE = 2'd2
    } calc_state_t;

    // lower limit of a band in Hz; index BAND_N gives the top of the range
    function automatic logic [FREQ_W-1:0] band_floor_hz(input logic [BAND_W-1:0] b);
        int mhz;
        case (b)
            5'd0:  mhz = 10;   5'd1:  mhz = 11;   5'd2:  mhz = 12;
            5'd3:  mhz = 13;   5'd4:  mhz = 15;   5'd5:  mhz = 17;
            5'd6:  mhz = 19;   5'd7:  mhz = 21;   5'd8:  mhz = 23;
            5'd9:  mhz = 25;   5'd10: mhz = 28;   5'd11: mhz = 32;
            5'd12: mhz = 36;   5'd13: mhz = 41;   5'd14: mhz = 47;
            5'd15: mhz = 54;   5'd16: mhz = 61;   5'd17: mhz = 70;
            5'd18: mhz = 81;   5'd19: mhz = 90;   5'd20: mhz = 101;
            5'd21: mhz = 111;  5'd22: mhz = 128;  5'd23: mhz = 135;
            default: mhz = 157;
        endcase
        return FREQ_W'(mhz * 1_000_000);
    endfunction

endpackage

// File: rtl/freqword_table.sv
module freqword_table
    import freqword_pkg::*;
#(
    parameter int N  = BAND_N,
    parameter int IW = BAND_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [IW-1:0] wr_idx,
    input  band_entry_t wr_entry,
    input  logic [IW-1:0] rd_idx,
    output band_entry_t rd_entry
);

    band_entry_t tab_d [N];
    band_entry_t tab_q [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            tab_d[i] = tab_q[i];
            if (we && (wr_idx == IW'(i))) tab_d[i] = wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) tab_q[i] <= '0;
            else        tab_q[i] <= tab_d[i];
        end
    end

    always_comb begin
        rd_entry = '0;
        for (int i = 0; i < N; i++)
            if (rd_idx == IW'(i)) rd_entry = tab_q[i];
    end

endmodule

// File: rtl/freqword_divider.sv
module freqword_divider #(
    parameter int DVS_W = 32,
    parameter int Q_W   = 38
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DVS_W-1:0] rem_init,
    input  logic [Q_W-1:0]   tail_init,
    input  logic [DVS_W-1:0] divisor,
    output logic [Q_W-1:0]   quot,
    output logic             fin
);

    localparam int CW = $clog2(Q_W);

    typedef struct packed {
        logic [DVS_W-1:0] rem;
        logic [Q_W-1:0]   tail;
        logic [Q_W-1:0]   quot;
        logic [DVS_W-1:0] dvs;
        logic [CW-1:0]    cnt;
        logic             active;
        logic             fin;
    } div_state_t;

    div_state_t s_d, s_q;
    logic [DVS_W:0] trial;

    always_comb begin
        s_d     = s_q;
        s_d.fin = 1'b0;
        trial   = {s_q.rem, s_q.tail[Q_W-1]};
        if (load) begin
            s_d.rem    = rem_init;
            s_d.tail   = tail_init;
            s_d.quot   = '0;
            s_d.dvs    = divisor;
            s_d.cnt    = '0;
            s_d.active = 1'b1;
        end else if (s_q.active) begin
            if (trial >= {1'b0, s_q.dvs}) begin
                s_d.rem  = trial[DVS_W-1:0] - s_q.dvs;
                s_d.quot = {s_q.quot[Q_W-2:0], 1'b1};
            end else begin
                s_d.rem  = trial[DVS_W-1:0];
                s_d.quot = {s_q.quot[Q_W-2:0], 1'b0};
            end
            s_d.tail = s_q.tail << 1;
            s_d.cnt  = s_q.cnt + 1'b1;
            if (s_q.cnt == CW'(Q_W - 1)) begin
                s_d.active = 1'b0;
                s_d.fin    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign quot = s_q.quot;
    assign fin  = s_q.fin;

    // R7
    fin_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fin |=> !s_q.fin);

    // R7
    fin_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fin |-> !s_q.active);

endmodule

// File: rtl/freqword_packer.sv
module freqword_packer
    import freqword_pkg::*;
(
    input  logic [HSI_W-1:0]  hs_idx,
    input  logic [N1_W-1:0]   n1m1,
    input  logic [MULT_W-1:0] mult,
    output logic [IMG_W-1:0]  img
);

    always_comb begin
        img          = '0;
        img[47:45]   = hs_idx;
        img[44:40]   = n1m1[6:2];
        img[39:38]   = n1m1[1:0];
        img[37:0]    = mult;
    end

endmodule

// File: rtl/freqword_calc.sv
module freqword_calc
    import freqword_pkg::*;
#(
    parameter logic [FREQ_W-1:0] FREQ_LO = 32'd10_000_000,
    parameter logic [FREQ_W-1:0] FREQ_HI = 32'd157_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [FREQ_W-1:0]   freq_i,
    input  logic                tbl_we_i,
    input  logic [BAND_W-1:0]   tbl_idx_i,
    input  logic [CONST_W-1:0]  tbl_k_i,
    input  logic [HSI_W-1:0]    tbl_hs_idx_i,
    input  logic [N1_W-1:0]     tbl_n1m1_i,
    output logic [IMG_W-1:0]    img_o,
    output logic [BAND_W-1:0]   band_o,
    output logic                done_o,
    output logic                err_o
);

    localparam int WIDE_W = FREQ_W + SCALE_SH;

    typedef struct packed {
        calc_state_t        st;
        logic [FREQ_W-1:0]  freq;
        logic [BAND_W-1:0]  idx;
        logic [HSI_W-1:0]   hs_idx;
        logic [N1_W-1:0]    n1m1;
        logic [IMG_W-1:0]   img;
        logic [BAND_W-1:0]  band;
        logic               done;
        logic               err;
    } calc_regs_t;

    calc_regs_t r_d, r_q;

    band_entry_t        wr_entry, rd_entry;
    logic               div_load, div_fin;
    logic [MULT_W-1:0]  div_quot;
    logic [WIDE_W-1:0]  wide;
    logic [CONST_W-1:0] rem_init;
    logic [MULT_W-1:0]  tail_init;
    logic [IMG_W-1:0]   packed_img;
    logic               step_up;

    assign wr_entry = '{k: tbl_k_i, hs_idx: tbl_hs_idx_i, n1m1: tbl_n1m1_i};

    freqword_table u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (tbl_we_i),
        .wr_idx   (tbl_idx_i),
        .wr_entry (wr_entry),
        .rd_idx   (r_q.idx),
        .rd_entry (rd_entry)
    );

    // dividend is F << SCALE_SH; the part above the quotient width seeds the remainder
    assign wide      = {r_q.freq, {SCALE_SH{1'b0}}};
    assign rem_init  = CONST_W'(wide[WIDE_W-1:MULT_W]);
    assign tail_init = wide[MULT_W-1:0];

    freqword_divider #(.DVS_W(CONST_W), .Q_W(MULT_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (div_load),
        .rem_init  (rem_init),
        .tail_init (tail_init),
        .divisor   (rd_entry.k),
        .quot      (div_quot),
        .fin       (div_fin)
    );

    freqword_packer u_pack (
        .hs_idx (r_q.hs_idx),
        .n1m1   (r_q.n1m1),
        .mult   (div_quot),
        .img    (packed_img)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        div_load = 1'b0;
        step_up  = (r_q.idx < BAND_W'(BAND_N - 1)) &&
                   (r_q.freq >= band_floor_hz(r_q.idx + 1'b1));
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (freq_i >= FREQ_LO && freq_i < FREQ_HI) begin
                        r_d.freq = freq_i;
                        r_d.idx  = '0;
                        r_d.st   = ST_SEARCH;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
            end
            ST_SEARCH: begin
                if (step_up) begin
                    r_d.idx = r_q.idx + 1'b1;
                end else begin
                    div_load   = 1'b1;
                    r_d.hs_idx = rd_entry.hs_idx;
                    r_d.n1m1   = rd_entry.n1m1;
                    r_d.st     = ST_DIVIDE;
                end
            end
            ST_DIVIDE: begin
                if (div_fin) begin
                    r_d.img  = packed_img;
                    r_d.band = r_q.idx;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign img_o  = r_q.img;
    assign band_o = r_q.band;
    assign done_o = r_q.done;
    assign err_o  = r_q.err;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);

    // R6
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.done && r_q.err));

    // R6
    img_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.done |-> ($stable(r_q.img) && $stable(r_q.band)));

    // R2
    search_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SEARCH) |-> (r_q.freq >= band_floor_hz(r_q.idx)));

    // R2
    band_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (r_q.band < BAND_W'(BAND_N)));

endmodule

// File: tb/freqword_calc_tb.sv
module freqword_calc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] freq_i = '0;
    logic        tbl_we_i = 1'b0;
    logic [4:0]  tbl_idx_i = '0;
    logic [31:0] tbl_k_i = '0;
    logic [2:0]  tbl_hs_idx_i = '0;
    logic [6:0]  tbl_n1m1_i = '0;
    logic [47:0] img_o;
    logic [4:0]  band_o;
    logic        done_o, err_o;

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 0;

    // bench copy of the table contents
    logic [31:0] m_k   [24];
    logic [2:0]  m_hs  [24];
    logic [6:0]  m_n1m1[24];

    always #4 clk = ~clk;

    freqword_calc u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .freq_i(freq_i),
        .tbl_we_i(tbl_we_i), .tbl_idx_i(tbl_idx_i), .tbl_k_i(tbl_k_i),
        .tbl_hs_idx_i(tbl_hs_idx_i), .tbl_n1m1_i(tbl_n1m1_i),
        .img_o(img_o), .band_o(band_o), .done_o(done_o), .err_o(err_o)
    );

    function automatic logic [31:0] floor_mhz(input int b);
        int t [25] = '{10,11,12,13,15,17,19,21,23,25,28,32,36,41,47,54,61,70,81,90,101,111,128,135,157};
        return 32'(t[b] * 1_000_000);
    endfunction

    function automatic int exp_band(input logic [31:0] f);
        int b = 0;
        for (int i = 0; i < 24; i++) if (f >= floor_mhz(i)) b = i;
        return b;
    endfunction

    function automatic int hs_of(input logic [2:0] ix);
        return (ix == 3'd5) ? 9 : (ix == 3'd7) ? 11 : 4 + int'(ix);
    endfunction

    function automatic logic [47:0] exp_img(input logic [31:0] f);
        int b = exp_band(f);
        logic [127:0] num = {96'b0, f} << 36;
        logic [127:0] q   = num / {96'b0, m_k[b]};
        logic [37:0]  m   = q[37:0];
        return {m_hs[b], m_n1m1[b], m};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    task automatic wr_entry(input int b, input logic [2:0] hsi, input int n1);
        logic [63:0] k = (64'd114_285_000 * 64'd256) / 64'(hs_of(hsi) * n1);
        @(negedge clk);
        tbl_we_i = 1'b1; tbl_idx_i = 5'(b); tbl_k_i = k[31:0];
        tbl_hs_idx_i = hsi; tbl_n1m1_i = 7'(n1 - 1);
        m_k[b] = k[31:0]; m_hs[b] = hsi; m_n1m1[b] = 7'(n1 - 1);
        @(negedge clk);
        tbl_we_i = 1'b0;
    endtask

    // valid request: checks band (R2), image (R3/R4), latency and pulse (R7)
    task automatic run_valid(input logic [31:0] f);
        int k = 1;
        int b = exp_band(f);
        @(negedge clk); start_i = 1'b1; freq_i = f;
        @(negedge clk); start_i = 1'b0;
        while (!done_o && k < 200) begin
            chk(!err_o, "R6 no error on valid request", 64'(err_o), 64'd0);
            @(negedge clk); k++;
        end
        chk(k - 1 == b + 40, "R7 latency", 64'(k - 1), 64'(b + 40));
        chk(band_o == 5'(b), "R2 band", 64'(band_o), 64'(b));
        chk(img_o == exp_img(f), "R3 R4 image", 64'(img_o), 64'(exp_img(f)));
        @(negedge clk);
        chk(!done_o, "R7 done one cycle", 64'(done_o), 64'd0);
    endtask

    task automatic run_reject(input logic [31:0] f);
        logic [47:0] img0 = img_o;
        logic [4:0]  band0 = band_o;
        int dones = 0;
        @(negedge clk); start_i = 1'b1; freq_i = f;
        @(negedge clk); start_i = 1'b0;
        chk(err_o, "R6 error pulse", 64'(err_o), 64'd1);
        @(negedge clk);
        chk(!err_o, "R6 error one cycle", 64'(err_o), 64'd0);
        for (int i = 0; i < 70; i++) begin
            if (done_o) dones++;
            @(negedge clk);
        end
        chk(dones == 0, "R6 no done on reject", 64'(dones), 64'd0);
        chk(img_o == img0 && band_o == band0, "R6 image kept", 64'(img_o), 64'(img0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        logic [2:0] hs_list [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd7};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(img_o == '0, "R1 image reset", 64'(img_o), 64'd0);
        chk(band_o == '0, "R1 band reset", 64'(band_o), 64'd0);
        chk(!done_o && !err_o, "R1 flags reset", 64'({done_o, err_o}), 64'd0);

        for (int b = 0; b < 24; b++) wr_entry(b, hs_list[b % 6], 2 * (b % 5) + 2);

        // R5 worked example in band 3
        wr_entry(3, 3'd7, 34);
        run_valid(32'd14_025_000);
        chk(img_o[47:40] == 8'hE8, "R5 byte0", 64'(img_o[47:40]), 64'hE8);
        chk(img_o[39:32] == 8'h42, "R5 byte1", 64'(img_o[39:32]), 64'h42);

        // R9 rewrite the entry; the next request must use the new constant
        begin
            logic [47:0] old_img = img_o;
            wr_entry(3, 3'd2, 80);
            run_valid(32'd14_025_000);
            chk(img_o != old_img, "R9 rewritten entry used", 64'(img_o), 64'(old_img));
        end

        // R2 R3 R4 R7 sweep: every band at its limit, inside, and just below the next
        for (int b = 0; b < 24; b++) begin
            logic [31:0] lo = floor_mhz(b);
            logic [31:0] hi = floor_mhz(b + 1);
            run_valid(lo);
            run_valid(lo + ((hi - lo) / 3) + 32'd7);
            run_valid(hi - 32'd1);
        end

        // R6 both sides of the range
        run_reject(32'd9_999_999);
        run_reject(32'd157_000_000);
        run_reject(32'd0);
        run_reject(32'hFFFF_FFFF);

        // R8 start during a busy request is ignored
        begin
            int k = 1;
            int errs = 0;
            int dones = 0;
            @(negedge clk); start_i = 1'b1; freq_i = 32'd20_000_000;
            @(negedge clk); start_i = 1'b0;
            repeat (4) @(negedge clk);
            start_i = 1'b1; freq_i = 32'd5_000_000;
            @(negedge clk); start_i = 1'b0;
            for (int i = 0; i < 80; i++) begin
                if (err_o) errs++;
                if (done_o) dones++;
                if (dones == 0) k++;
                @(negedge clk);
            end
            freq_i = 32'd20_000_000;
            chk(errs == 0, "R8 no error from busy start", 64'(errs), 64'd0);
            chk(dones == 1, "R8 single done", 64'(dones), 64'd1);
            chk(band_o == 5'd6, "R8 band kept", 64'(band_o), 64'd6);
            chk(img_o == exp_img(32'd20_000_000), "R8 result kept", 64'(img_o),
                64'(exp_img(32'd20_000_000)));
        end

        report();
    end

endmodule